// File: doc/BRIEF.md
# Lockable Motor-Driver Configuration Register Bank

This block is a byte-wide register bank that holds the configuration of a motor-driver controller and presents its status. Twelve addresses, 0x00 to 0x0B, are decoded. The first three addresses show live status bytes that are supplied by the fault logic. Addresses 0x03 to 0x09 are writable control registers. Addresses 0x0A and 0x0B show a captured 12-bit torque count and a revision nibble. Writes use a single-cycle strobe with an address and a data byte. Reads are combinational from a separate read address.

A three-bit key field at address 0x06 can freeze the whole configuration. While the bank is frozen, the only things a write can still do are re-open the bank and fire a fault-clear command. Three command bits clear themselves after a write:
- The step bit and the fault-clear bit each become a one-cycle pulse.
- The learn-request bit stays set until an external done signal arrives.

Every configuration field is also decoded onto its own output port for the rest of the design.

Top module: `motor_cfg_regbank`

## Requirements
- R1: The key field is bits 6:4 of address 0x06 and reads back 011b when the bank is open and 110b when it is frozen.
  - Writing 110b while open freezes the bank, and `locked_o` rises on the cycle after the write.
  - Writing 011b while frozen opens the bank.
  - Any other key value written leaves the state unchanged.
- R2: While frozen, writes to 0x03..0x09 change no stored bit, including bits 3:0 of 0x06 and the step bit. Only the key field and the fault-clear bit (0x06 bit 7) still take effect.
- R3: After reset, the readback values are as follows, and `locked_o`, `step_pulse_o`, `clr_pulse_o` and `learn_req_o` are 0.

  | Address | Value |
  |---|---|
  | 0x03 | 0x00 |
  | 0x04 | 0x0F |
  | 0x05 | 0x06 |
  | 0x06 | 0x30 |
  | 0x07 | 0x08 |
  | 0x08 | 0x03 |
  | 0x09 | 0x20 |
  | 0x0A | 0xFF |
  | 0x0B | 0x0F |

- R4: Self-clearing command bits:
  - Writing 1 to 0x05 bit 6 while open makes `step_pulse_o` high for exactly the cycle after the write.
  - Writing 1 to 0x06 bit 7, open or frozen, does the same for `clr_pulse_o`.
  - Both bits read back as 0.
- R5: Writing 1 to 0x07 bit 5 while open sets `learn_req_o`, and the bit reads back as 1. It stays set until `learn_done_i` is high at a clock edge, and then it reads 0.
- R6: The decoded outputs take their values from these fields:

  | Output | Field |
  |---|---|
  | `torque_code_o` | 0x03[7:4] |
  | `ol_release_o` | 0x03[1] |
  | `out_en_o` | 0x04[7] |
  | `off_time_o` | 0x04[4:3] |
  | `decay_o` | 0x04[2:0] |
  | `dir_o` | 0x05[7] |
  | `dir_from_reg_o` | 0x05[5] |
  | `step_from_reg_o` | 0x05[4] |
  | `ustep_o` | 0x05[3:0] |
  | `ol_det_en_o` | 0x06[3] |
  | `ocp_retry_o` | 0x06[2] |
  | `ot_autorec_o` | 0x06[1] |
  | `warn_rep_o` | 0x06[0] |
  | `stall_en_o` | 0x07[4] |
  | `stall_rep_o` | 0x07[3] |
  | `ripple_o` | 0x09[7:6] |
  | `ssc_en_o` | 0x09[5] |
  | `cnt_scale_o` | 0x09[4] |

  The 12-bit `stall_thr_o` is {0x09[3:0], 0x08[7:0]}.
- R7: Addresses 0x00, 0x01 and 0x02 read the live inputs `fault_flags_i`, `diag_bridge_i` and `diag_misc_i`. Writes to these addresses are dropped.
- R8: The count is captured from `torque_cnt_i` at every clock edge. 0x0A reads count[7:0], and 0x0B reads {REV_ID, count[11:8]}. Writes to these addresses are dropped.
- R9: Writes to addresses above 0x0B change nothing, and reads there return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data (combinational) |
| fault_flags_i | input | 8 | Summary fault status byte |
| diag_bridge_i | input | 8 | Bridge overcurrent status byte |
| diag_misc_i | input | 8 | Thermal / stall / open-load status byte |
| torque_cnt_i | input | 12 | Torque count from the stall monitor |
| learn_done_i | input | 1 | Stall learning finished |
| step_pulse_o | output | 1 | One-cycle step command |
| clr_pulse_o | output | 1 | One-cycle fault-clear command |
| learn_req_o | output | 1 | Stall learning requested |
| locked_o | output | 1 | Bank frozen |
| torque_code_o | output | 4 | Current scaling code |
| ol_release_o | output | 1 | Open-load fault release mode |
| out_en_o | output | 1 | Output stage enable |
| off_time_o | output | 2 | PWM off-time code |
| decay_o | output | 3 | Decay mode code |
| dir_o | output | 1 | Register direction |
| dir_from_reg_o | output | 1 | Direction taken from register |
| step_from_reg_o | output | 1 | Step taken from register |
| ustep_o | output | 4 | Microstep mode code |
| ol_det_en_o | output | 1 | Open-load detection enable |
| ocp_retry_o | output | 1 | Overcurrent auto-retry mode |
| ot_autorec_o | output | 1 | Overtemperature auto-recovery mode |
| warn_rep_o | output | 1 | Thermal warning reporting enable |
| stall_en_o | output | 1 | Stall detection enable |
| stall_rep_o | output | 1 | Stall reporting enable |
| stall_thr_o | output | 12 | Stall threshold |
| ripple_o | output | 2 | Ripple setting code |
| ssc_en_o | output | 1 | Spread-spectrum enable |
| cnt_scale_o | output | 1 | Torque count scaling enable |

## Verification
The bench builds the block with its default parameters: an 8-bit address and a revision nibble of 0. The 8-bit address puts addresses 0x0C through 0xFF within reach, so writes and reads beyond the decoded range can be driven at both the first unused address and the very top of the space. The revision default makes the expected high nibble of 0x0B zero. The bench also holds a distinct count value through reset, which shows that the reset count comes from the bank and not from the input.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

    localparam int DW         = 8;
    localparam int CNT_W      = 12;
    localparam int FIRST_CTRL = 3;
    localparam int NUM_CTRL   = 7;

    localparam int A_FLAGS  = 0;
    localparam int A_BRIDGE = 1;
    localparam int A_MISC   = 2;
    localparam int A_STEPR  = 5;
    localparam int A_GUARD  = 6;
    localparam int A_LEARN  = 7;
    localparam int A_CNT_LO = 10;
    localparam int A_CNT_HI = 11;

    localparam int IX_GUARD = A_GUARD - FIRST_CTRL;
    localparam int IX_LEARN = A_LEARN - FIRST_CTRL;

    localparam logic [2:0] KEY_FREEZE = 3'b110;
    localparam logic [2:0] KEY_OPEN   = 3'b011;

    typedef enum logic {
        BANK_OPEN   = 1'b0,
        BANK_FROZEN = 1'b1
    } bank_state_t;

    typedef logic [NUM_CTRL-1:0][DW-1:0] ctrl_view_t;

    typedef struct packed {
        logic [3:0]       torque_code;
        logic             ol_release;
        logic             out_en;
        logic [1:0]       off_time;
        logic [2:0]       decay;
        logic             dir;
        logic             dir_from_reg;
        logic             step_from_reg;
        logic [3:0]       ustep;
        logic             ol_det_en;
        logic             ocp_retry;
        logic             ot_autorec;
        logic             warn_rep;
        logic             stall_en;
        logic             stall_rep;
        logic [CNT_W-1:0] stall_thr;
        logic [1:0]       ripple;
        logic             ssc_en;
        logic             cnt_scale;
    } cfg_t;

    // Reset value of each stored control byte (index 0 is address 0x03).
    function automatic logic [DW-1:0] ctrl_reset(input int idx);
        case (idx)
            1:       return 8'h0F;
            2:       return 8'h06;
            4:       return 8'h08;
            5:       return 8'h03;
            6:       return 8'h20;
            default: return 8'h00;
        endcase
    endfunction

    // Bits a write may store; command and key bits are handled elsewhere.
    function automatic logic [DW-1:0] ctrl_wmask(input int idx);
        case (idx)
            2:       return 8'hBF;
            3:       return 8'h0F;
            4:       return 8'hDF;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic cfg_t decode_cfg(input ctrl_view_t v);
        cfg_t c;
        c.torque_code   = v[0][7:4];
        c.ol_release    = v[0][1];
        c.out_en        = v[1][7];
        c.off_time      = v[1][4:3];
        c.decay         = v[1][2:0];
        c.dir           = v[2][7];
        c.dir_from_reg  = v[2][5];
        c.step_from_reg = v[2][4];
        c.ustep         = v[2][3:0];
        c.ol_det_en     = v[3][3];
        c.ocp_retry     = v[3][2];
        c.ot_autorec    = v[3][1];
        c.warn_rep      = v[3][0];
        c.stall_en      = v[4][4];
        c.stall_rep     = v[4][3];
        c.stall_thr     = {v[6][3:0], v[5]};
        c.ripple        = v[6][7:6];
        c.ssc_en        = v[6][5];
        c.cnt_scale     = v[6][4];
        return c;
    endfunction

endpackage

// File: rtl/mcr_guard.sv
module mcr_guard
    import mcr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       key_wr,
    input  logic [2:0] key,
    output logic       frozen,
    output logic [2:0] key_field
);
    bank_state_t state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BANK_OPEN;
        end else if (key_wr) begin
            if (state_q == BANK_OPEN && key == KEY_FREEZE)
                state_q <= BANK_FROZEN;
            else if (state_q == BANK_FROZEN && key == KEY_OPEN)
                state_q <= BANK_OPEN;
        end
    end

    assign frozen    = (state_q == BANK_FROZEN);
    assign key_field = frozen ? KEY_FREEZE : KEY_OPEN;

    AST_FREEZE_NEEDS_KEY: assert property (@(posedge clk) disable iff (rst)
        $rose(frozen) |-> $past(key_wr && key == KEY_FREEZE)); // R1
    AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (rst)
        $fell(frozen) |-> $past(key_wr && key == KEY_OPEN)); // R1

endmodule

// File: rtl/mcr_ctrl_store.sv
module mcr_ctrl_store
    import mcr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              frozen,
    input  logic              learn_done,
    output ctrl_view_t        view,
    output logic              step_pulse,
    output logic              clr_pulse,
    output logic              learn_req
);
    logic [NUM_CTRL-1:0][DW-1:0] store_q;
    logic step_q, clr_q, learn_q;

    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_reg
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(FIRST_CTRL + i);
        localparam logic [DW-1:0]     RST_V   = ctrl_reset(i);
        localparam logic [DW-1:0]     WMASK   = ctrl_wmask(i);
        logic hit;
        assign hit = wr_en && !frozen && (wr_addr == MY_ADDR);

        always_ff @(posedge clk) begin
            if (rst)
                store_q[i] <= RST_V;
            else if (hit)
                store_q[i] <= wr_data & WMASK;
        end

        AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (rst)
            frozen && wr_en && wr_addr == MY_ADDR |=> $stable(store_q[i])); // R2
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q  <= 1'b0;
            clr_q   <= 1'b0;
            learn_q <= 1'b0;
        end else begin
            step_q <= wr_en && !frozen && wr_addr == ADDR_W'(A_STEPR) && wr_data[6];
            clr_q  <= wr_en && wr_addr == ADDR_W'(A_GUARD) && wr_data[7];
            if (wr_en && !frozen && wr_addr == ADDR_W'(A_LEARN) && wr_data[5])
                learn_q <= 1'b1;
            else if (learn_done)
                learn_q <= 1'b0;
        end
    end

    always_comb begin
        view = store_q;
        view[IX_LEARN][5] = learn_q;
    end

    assign step_pulse = step_q;
    assign clr_pulse  = clr_q;
    assign learn_req  = learn_q;

    AST_STEP_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        step_pulse |-> $past(wr_en && !frozen && wr_addr == ADDR_W'(A_STEPR))); // R4
    AST_LEARN_STICKS: assert property (@(posedge clk) disable iff (rst)
        learn_req && !learn_done |=> learn_req); // R5

endmodule

// File: rtl/mcr_cnt_cap.sv
module mcr_cnt_cap
    import mcr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_in,
    output logic [CNT_W-1:0] cnt_q
);
    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '1;
        else     cnt_q <= cnt_in;
    end

    AST_CNT_TRACKS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> cnt_q == $past(cnt_in)); // R8

endmodule

// File: rtl/mcr_rd_mux.sv
module mcr_rd_mux
    import mcr_pkg::*;
#(
    parameter int         ADDR_W = 8,
    parameter logic [3:0] REV_ID = 4'h0
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DW-1:0]     flags,
    input  logic [DW-1:0]     bridge,
    input  logic [DW-1:0]     misc,
    input  ctrl_view_t        view,
    input  logic [2:0]        key_field,
    input  logic [CNT_W-1:0]  cnt,
    output logic [DW-1:0]     rd_data
);
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(A_FLAGS))       rd_data = flags;
        else if (rd_addr == ADDR_W'(A_BRIDGE)) rd_data = bridge;
        else if (rd_addr == ADDR_W'(A_MISC))   rd_data = misc;
        else if (rd_addr == ADDR_W'(A_CNT_LO)) rd_data = cnt[7:0];
        else if (rd_addr == ADDR_W'(A_CNT_HI)) rd_data = {REV_ID, cnt[11:8]};
        else begin
            for (int i = 0; i < NUM_CTRL; i++) begin
                if (rd_addr == ADDR_W'(FIRST_CTRL + i)) begin
                    rd_data = view[i];
                    if (i == IX_GUARD) rd_data[6:4] = key_field;
                end
            end
        end
    end

endmodule

// File: rtl/motor_cfg_regbank.sv
module motor_cfg_regbank
    import mcr_pkg::*;
#(
    parameter int         ADDR_W = 8,
    parameter logic [3:0] REV_ID = 4'h0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic [7:0]        fault_flags_i,
    input  logic [7:0]        diag_bridge_i,
    input  logic [7:0]        diag_misc_i,
    input  logic [11:0]       torque_cnt_i,
    input  logic              learn_done_i,
    output logic              step_pulse_o,
    output logic              clr_pulse_o,
    output logic              learn_req_o,
    output logic              locked_o,
    output logic [3:0]        torque_code_o,
    output logic              ol_release_o,
    output logic              out_en_o,
    output logic [1:0]        off_time_o,
    output logic [2:0]        decay_o,
    output logic              dir_o,
    output logic              dir_from_reg_o,
    output logic              step_from_reg_o,
    output logic [3:0]        ustep_o,
    output logic              ol_det_en_o,
    output logic              ocp_retry_o,
    output logic              ot_autorec_o,
    output logic              warn_rep_o,
    output logic              stall_en_o,
    output logic              stall_rep_o,
    output logic [11:0]       stall_thr_o,
    output logic [1:0]        ripple_o,
    output logic              ssc_en_o,
    output logic              cnt_scale_o
);
    logic             frozen;
    logic [2:0]       key_field;
    ctrl_view_t       view;
    logic [CNT_W-1:0] cnt_q;
    cfg_t             cfg;

    mcr_guard u_guard (
        .clk       (clk),
        .rst       (rst),
        .key_wr    (wr_en && wr_addr == ADDR_W'(A_GUARD)),
        .key       (wr_data[6:4]),
        .frozen    (frozen),
        .key_field (key_field)
    );

    mcr_ctrl_store #(.ADDR_W(ADDR_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .frozen     (frozen),
        .learn_done (learn_done_i),
        .view       (view),
        .step_pulse (step_pulse_o),
        .clr_pulse  (clr_pulse_o),
        .learn_req  (learn_req_o)
    );

    mcr_cnt_cap u_cnt (
        .clk    (clk),
        .rst    (rst),
        .cnt_in (torque_cnt_i),
        .cnt_q  (cnt_q)
    );

    mcr_rd_mux #(.ADDR_W(ADDR_W), .REV_ID(REV_ID)) u_rd (
        .rd_addr   (rd_addr),
        .flags     (fault_flags_i),
        .bridge    (diag_bridge_i),
        .misc      (diag_misc_i),
        .view      (view),
        .key_field (key_field),
        .cnt       (cnt_q),
        .rd_data   (rd_data)
    );

    assign cfg             = decode_cfg(view);
    assign locked_o        = frozen;
    assign torque_code_o   = cfg.torque_code;
    assign ol_release_o    = cfg.ol_release;
    assign out_en_o        = cfg.out_en;
    assign off_time_o      = cfg.off_time;
    assign decay_o         = cfg.decay;
    assign dir_o           = cfg.dir;
    assign dir_from_reg_o  = cfg.dir_from_reg;
    assign step_from_reg_o = cfg.step_from_reg;
    assign ustep_o         = cfg.ustep;
    assign ol_det_en_o     = cfg.ol_det_en;
    assign ocp_retry_o     = cfg.ocp_retry;
    assign ot_autorec_o    = cfg.ot_autorec;
    assign warn_rep_o      = cfg.warn_rep;
    assign stall_en_o      = cfg.stall_en;
    assign stall_rep_o     = cfg.stall_rep;
    assign stall_thr_o     = cfg.stall_thr;
    assign ripple_o        = cfg.ripple;
    assign ssc_en_o        = cfg.ssc_en;
    assign cnt_scale_o     = cfg.cnt_scale;

    AST_OOR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_addr > ADDR_W'(A_CNT_HI) |-> rd_data == 8'h00); // R9
    AST_CLEAR_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        clr_pulse_o |-> $past(wr_en && wr_addr == ADDR_W'(A_GUARD) && wr_data[7])); // R4

endmodule

// File: tb/tb_motor_cfg_regbank.sv
module tb_motor_cfg_regbank;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic [7:0]    flags = '0, bridge = '0, misc = '0;
    logic [11:0]   cnt_in = 12'h123;
    logic          learn_done = 1'b0;
    logic step_p, clr_p, learn_r, locked;
    logic [3:0] torque, ustep;
    logic ol_rel, out_en, dir, dir_r, step_r, ol_en, ocp_r, ot_a, warn, st_en, st_rep, ssc, scale;
    logic [1:0] off_t, ripple;
    logic [2:0] decay;
    logic [11:0] thr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    motor_cfg_regbank #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .fault_flags_i(flags), .diag_bridge_i(bridge), .diag_misc_i(misc),
        .torque_cnt_i(cnt_in), .learn_done_i(learn_done),
        .step_pulse_o(step_p), .clr_pulse_o(clr_p), .learn_req_o(learn_r), .locked_o(locked),
        .torque_code_o(torque), .ol_release_o(ol_rel), .out_en_o(out_en),
        .off_time_o(off_t), .decay_o(decay), .dir_o(dir), .dir_from_reg_o(dir_r),
        .step_from_reg_o(step_r), .ustep_o(ustep), .ol_det_en_o(ol_en),
        .ocp_retry_o(ocp_r), .ot_autorec_o(ot_a), .warn_rep_o(warn),
        .stall_en_o(st_en), .stall_rep_o(st_rep), .stall_thr_o(thr),
        .ripple_o(ripple), .ssc_en_o(ssc), .cnt_scale_o(scale)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [7:0] a, input logic [7:0] exp);
        rd_addr = a;
        #1;
        check(tag, {24'h0, rd_data}, {24'h0, exp});
    endtask

    task automatic t_reset;
        // R3: sampled while reset is still held; count input differs from default
        rd_check("R3 0x03", 8'h03, 8'h00);
        rd_check("R3 0x04", 8'h04, 8'h0F);
        rd_check("R3 0x05", 8'h05, 8'h06);
        rd_check("R3 0x06", 8'h06, 8'h30);
        rd_check("R3 0x07", 8'h07, 8'h08);
        rd_check("R3 0x08", 8'h08, 8'h03);
        rd_check("R3 0x09", 8'h09, 8'h20);
        rd_check("R3 0x0A", 8'h0A, 8'hFF);
        rd_check("R3 0x0B", 8'h0B, 8'h0F);
        check("R3 flags out", {28'h0, locked, step_p, clr_p, learn_r}, 32'h0);
    endtask

    task automatic t_decode;
        wr(8'h08, 8'hAB);
        wr(8'h09, 8'hC5);
        wr(8'h03, 8'hA2);
        wr(8'h04, 8'h9A);
        check("R6 stall_thr", {20'h0, thr}, 32'h5AB);
        check("R6 ripple/ssc/scale", {28'h0, ripple, ssc, scale}, 32'hC);
        check("R6 torque/olrel", {27'h0, torque, ol_rel}, 32'h15);
        check("R6 en/off/decay", {26'h0, out_en, off_t, decay}, 32'h3A);
        wr(8'h06, 8'h35);
        check("R6 guard low bits", {28'h0, ol_en, ocp_r, ot_a, warn}, 32'h5);
        wr(8'h07, 8'h10);
        check("R6 stall en/rep", {30'h0, st_en, st_rep}, 32'h2);
    endtask

    task automatic t_status;
        flags = 8'h81; bridge = 8'h3C; misc = 8'h5A;
        rd_check("R7 read 0x00", 8'h00, 8'h81);
        rd_check("R7 read 0x01", 8'h01, 8'h3C);
        rd_check("R7 read 0x02", 8'h02, 8'h5A);
        wr(8'h01, 8'h00);
        wr(8'h02, 8'hFF);
        rd_check("R7 0x01 after write", 8'h01, 8'h3C);
        rd_check("R7 0x02 after write", 8'h02, 8'h5A);
    endtask

    task automatic t_count;
        @(negedge clk);
        cnt_in = 12'hABC;
        @(negedge clk);
        rd_check("R8 count low", 8'h0A, 8'hBC);
        rd_check("R8 count high+rev", 8'h0B, 8'h0A);
        wr(8'h0A, 8'h00);
        rd_check("R8 count low after write", 8'h0A, 8'hBC);
    endtask

    task automatic t_pulses;
        wr(8'h05, 8'h5F);
        check("R4 step pulse high", {31'h0, step_p}, 32'h1);
        check("R6 dir/src/ustep", {25'h0, dir, dir_r, step_r, ustep}, 32'h1F);
        @(negedge clk);
        check("R4 step pulse one cycle", {31'h0, step_p}, 32'h0);
        rd_check("R4 step bit reads 0", 8'h05, 8'h1F);
        wr(8'h06, 8'hB5);
        check("R4 clr pulse high", {31'h0, clr_p}, 32'h1);
        @(negedge clk);
        check("R4 clr pulse one cycle", {31'h0, clr_p}, 32'h0);
        rd_check("R4 clr bit reads 0", 8'h06, 8'h35);
    endtask

    task automatic t_learn;
        wr(8'h07, 8'h28);
        check("R5 learn set", {31'h0, learn_r}, 32'h1);
        rd_check("R5 learn reads 1", 8'h07, 8'h28);
        repeat (3) @(negedge clk);
        check("R5 learn holds", {31'h0, learn_r}, 32'h1);
        learn_done = 1'b1;
        @(negedge clk);
        learn_done = 1'b0;
        check("R5 learn cleared", {31'h0, learn_r}, 32'h0);
        rd_check("R5 learn reads 0", 8'h07, 8'h08);
    endtask

    task automatic t_lock;
        wr(8'h06, 8'h55);
        check("R1 bad key keeps open", {31'h0, locked}, 32'h0);
        rd_check("R1 open key field", 8'h06, 8'h35);
        wr(8'h06, 8'h6A);
        check("R1 freeze key", {31'h0, locked}, 32'h1);
        rd_check("R1 frozen readback", 8'h06, 8'h6A);
        wr(8'h03, 8'hFF);
        rd_check("R2 0x03 frozen", 8'h03, 8'hA2);
        check("R2 torque unchanged", {28'h0, torque}, 32'hA);
        wr(8'h06, 8'h25);
        check("R1 bad key keeps frozen", {31'h0, locked}, 32'h1);
        rd_check("R2 0x06 low bits frozen", 8'h06, 8'h6A);
        wr(8'h06, 8'hE0);
        check("R4 clr while frozen", {31'h0, clr_p}, 32'h1);
        check("R1 still frozen", {31'h0, locked}, 32'h1);
        wr(8'h05, 8'h40);
        check("R2 step blocked", {31'h0, step_p}, 32'h0);
        rd_check("R2 0x05 frozen", 8'h05, 8'h1F);
        wr(8'h07, 8'h20);
        check("R2 learn blocked", {31'h0, learn_r}, 32'h0);
        wr(8'h06, 8'h31);
        check("R1 open key", {31'h0, locked}, 32'h0);
        rd_check("R2 unlock write keeps low bits", 8'h06, 8'h3A);
        wr(8'h03, 8'h11);
        rd_check("R2 write after open", 8'h03, 8'h11);
    endtask

    task automatic t_oor;
        wr(8'h0C, 8'h55);
        wr(8'hFF, 8'h55);
        rd_check("R9 read 0x0C", 8'h0C, 8'h00);
        rd_check("R9 read 0xFF", 8'hFF, 8'h00);
        rd_check("R9 0x03 intact", 8'h03, 8'h11);
        rd_check("R9 0x09 intact", 8'h09, 8'hC5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_decode();
        t_status();
        t_count();
        t_pulses();
        t_learn();
        t_lock();
        t_oor();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule